// File: doc/BRIEF.md
# Programmable Channel Clock Divider with Duty-Cycle Correction

This block divides an incoming clock by any integer from 1 to 32 and drives one output channel. Two 4-bit fields set the output's shape. The high field gives the number of input cycles the output stays high, minus one. The low field gives the number of input cycles it stays low, minus one. The division ratio is therefore the sum of both lengths, from 2 to 32. A bypass setting gives a ratio of 1 by routing the input clock straight to the output and leaving the counter idle.

Correction is on unless the disable field is set. It matters for odd ratios set with low = high + 1. In that case the high phase is lengthened by half an input cycle, and the output becomes exactly 50%. Even ratios set with low = high are already symmetric. Any other setting produces the raw duty cycle (high+1)/(high+low+2).

A start delay, counted in whole input cycles, sets the output phase. A sync strobe restarts the channel: it loads a new configuration and restarts the delay, so that several instances fed the same strobe stay aligned. The configuration is read only at a sync, or at the first clock edge after reset.

Top module: `clk_chan_div`

## Requirements
- R1: With correction disabled (dcc_off=1) and no bypass, the output period is high_cyc+low_cyc+2 input cycles. The output is high for high_cyc+1 cycles and low for low_cyc+1 cycles, and both edges are on rising input edges.
- R2: Each period starts with the high phase and is followed by the low phase. The internal cycle counter wraps to zero after exactly period-1.
- R3: With bypass=1 loaded, the output equals the input clock and the divider counter stays idle.
- R4: With correction on (dcc_off=0) and low_cyc = high_cyc+1, the output rises on a rising input edge. It stays high for high_cyc+1.5 input cycles, falling on a falling input edge, and then stays low for high_cyc+1.5 cycles.
- R5: With correction on and low_cyc = high_cyc, the output is high and low for high_cyc+1 cycles each, with edges on rising input edges.
- R6: With correction on and neither rule met, the output uses the raw high_cyc+1 / low_cyc+1 shape of R1.
- R7: After a load edge with start delay P, the output stays low for the next P+1 input cycles. The first high phase begins at the (P+1)-th rising edge after the load edge.
- R8: A sync sampled high on a rising edge restarts the channel in that cycle. The output goes low, the delay reloads from phase_dly, and the counter clears, even in the middle of a delay or a period.
- R9: Configuration inputs are captured only at a load edge. Changes made between syncs do not affect the output.
- R10: The output is low while rst_n is low. The first rising edge after reset is released acts as a load edge, exactly as a sync does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Restart strobe; loads the configuration and the start delay |
| low_cyc | input | CW | Low-phase length minus one |
| high_cyc | input | CW | High-phase length minus one |
| bypass | input | 1 | Divide by 1: the input clock goes to the output |
| dcc_off | input | 1 | 1 disables duty-cycle correction |
| phase_dly | input | PW | Start delay in whole input cycles |
| clk_out | output | 1 | Divided clock |

## Verification
On every cycle the assertions check the counter's invariants. The counter stays inside the period and wraps exactly at period-1. A sync clears the channel and reloads the delay. The captured configuration stays unchanged between loads, bypass keeps the counter idle, and every run starts high. Only the bench's half-cycle sampling of clk_out can show the actual waveform: the half-cycle stretch on odd corrected ratios, the exact start-delay alignment, and bypass following the clock. The same applies to the fact that configuration changes between syncs have no effect.

// File: rtl/clk_chan_div.sv
module clk_chan_div #(
  parameter int CW = 4,
  parameter int PW = 4
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          sync,
  input  logic [CW-1:0] low_cyc,
  input  logic [CW-1:0] high_cyc,
  input  logic          bypass,
  input  logic          dcc_off,
  input  logic [PW-1:0] phase_dly,
  output logic          clk_out
);
  localparam int DW = CW + 2;

  logic          pend, load;
  logic [CW-1:0] m_q, n_q;
  logic          byp_q, dccoff_q;
  logic [PW-1:0] dly;
  logic          active, q, qn, odd_fix;
  logic [DW-1:0] cnt, cnt_nxt, period, hi_len;

  assign load    = pend | sync;
  assign hi_len  = DW'(n_q) + DW'(1);
  assign period  = DW'(n_q) + DW'(m_q) + DW'(2);
  assign odd_fix = !dccoff_q && (DW'(m_q) == DW'(n_q) + DW'(1));
  assign cnt_nxt = (cnt == period - DW'(1)) ? '0 : cnt + DW'(1);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b1;
      m_q      <= '0;
      n_q      <= '0;
      byp_q    <= 1'b0;
      dccoff_q <= 1'b0;
      dly      <= '0;
      active   <= 1'b0;
      cnt      <= '0;
      q        <= 1'b0;
    end else if (load) begin
      pend     <= 1'b0;
      m_q      <= low_cyc;
      n_q      <= high_cyc;
      byp_q    <= bypass;
      dccoff_q <= dcc_off;
      dly      <= phase_dly;
      active   <= 1'b0;
      cnt      <= '0;
      q        <= 1'b0;
    end else if (!byp_q) begin
      if (!active) begin
        if (dly != '0) dly <= dly - PW'(1);
        else begin
          active <= 1'b1;
          cnt    <= '0;
          q      <= 1'b1;
        end
      end else begin
        cnt <= cnt_nxt;
        q   <= (cnt_nxt < hi_len);
      end
    end
  end

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) qn <= 1'b0;
    else        qn <= q;
  end

  assign clk_out = byp_q ? clk_in : (q | (odd_fix & active & qn));

  // R2
  cnt_range_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    active |-> cnt < period);

  // R2
  period_wrap_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (active && $past(active) && cnt == '0) |-> $past(cnt) == period - DW'(1));

  // R8
  sync_load_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    sync |=> (!active && !q && cnt == '0 && dly == $past(phase_dly)));

  // R9
  cfg_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !load |=> ($stable(m_q) && $stable(n_q) && $stable(byp_q) && $stable(dccoff_q)));

  // R3
  byp_idle_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    byp_q |-> (!active && !q));

  // R2
  start_high_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(active) |-> q);
endmodule

// File: tb/clk_chan_div_bench.sv
module clk_chan_div_bench;
  logic       clk_in = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic [3:0] low_cyc = '0, high_cyc = '0, phase_dly = '0;
  logic       bypass = 1'b0, dcc_off = 1'b0;
  logic       clk_out;
  int checks = 0, errors = 0;
  bit done = 0;

  clk_chan_div #(.CW(4), .PW(4)) u_clk_chan_div (
    .clk_in(clk_in), .rst_n(rst_n), .sync(sync), .low_cyc(low_cyc),
    .high_cyc(high_cyc), .bypass(bypass), .dcc_off(dcc_off),
    .phase_dly(phase_dly), .clk_out(clk_out));

  always #5 clk_in = ~clk_in;

  function automatic bit exp_q(int j, int m, int n, int p);
    int c;
    if (j < p + 1) return 1'b0;
    c = (j - p - 1) % (m + n + 2);
    return c < n + 1;
  endfunction

  function automatic bit exp_out(int j, int half, int m, int n, int p, bit off, bit byp);
    bit q;
    if (byp) return half == 0;
    q = exp_q(j, m, n, p);
    if (half == 1 || off || m != n + 1) return q;
    return q | exp_q(j - 1, m, n, p);
  endfunction

  task automatic chk(bit act, bit ex, string tag, int j, int half);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s cycle %0d half %0d actual=%0b expected=%0b", tag, j, half, act, ex);
    end
  endtask

  task automatic observe(int m, int n, int p, bit off, bit byp, string tag, int cyc, bit scramble);
    for (int j = 0; j < cyc; j++) begin
      @(posedge clk_in); #2;
      chk(clk_out, exp_out(j, 0, m, n, p, off, byp), tag, j, 0);
      @(negedge clk_in);
      sync = 1'b0;
      if (scramble && j == 2) begin
        low_cyc = 4'($urandom); high_cyc = 4'($urandom); phase_dly = 4'($urandom);
        bypass = ~bypass; dcc_off = ~dcc_off;
      end
      #2;
      chk(clk_out, exp_out(j, 1, m, n, p, off, byp), tag, j, 1);
    end
  endtask

  function automatic string tag_of(int m, int n, bit off, bit byp);
    if (byp) return "R3";
    if (off) return "R1";
    if (m == n + 1) return "R4";
    if (m == n) return "R5";
    return "R6";
  endfunction

  task automatic run_cfg(int m, int n, int p, bit off, bit byp, int cyc, bit scramble, string extra);
    @(negedge clk_in);
    low_cyc = 4'(m); high_cyc = 4'(n); phase_dly = 4'(p);
    dcc_off = off; bypass = byp; sync = 1'b1;
    observe(m, n, p, off, byp, {tag_of(m, n, off, byp), extra}, cyc, scramble);
  endtask

  initial begin
    repeat (150000) @(posedge clk_in);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    low_cyc = 4'd2; high_cyc = 4'd1; phase_dly = 4'd3; dcc_off = 1'b0; bypass = 1'b0;
    // R10: output low throughout reset
    for (int k = 0; k < 6; k++) begin
      #3;
      chk(clk_out, 1'b0, "R10 reset", k, 0);
    end
    @(negedge clk_in); rst_n = 1'b1;
    // R10: first edge after reset loads config like a sync
    observe(2, 1, 3, 1'b0, 1'b0, "R10/R4/R7", 16, 1'b0);

    // directed corners
    run_cfg(0, 0, 0, 1'b0, 1'b0, 8, 1'b0, "/R2 ratio2");
    run_cfg(15, 15, 0, 1'b0, 1'b0, 70, 1'b0, "/R2 ratio32");
    run_cfg(1, 0, 0, 1'b0, 1'b0, 10, 1'b0, " ratio3");
    run_cfg(15, 14, 2, 1'b0, 1'b0, 66, 1'b0, "/R7 ratio31");
    run_cfg(3, 0, 1, 1'b1, 1'b0, 12, 1'b0, "/R2 raw");
    run_cfg(5, 1, 0, 1'b0, 1'b0, 20, 1'b0, " unmet");
    run_cfg(1, 0, 0, 1'b1, 1'b0, 10, 1'b0, " odd no corr");
    run_cfg(7, 7, 0, 1'b0, 1'b1, 12, 1'b0, " bypass");
    run_cfg(2, 2, 15, 1'b0, 1'b0, 30, 1'b0, "/R7 max delay");
    // R8: restart while delay counts and mid-period
    run_cfg(3, 3, 10, 1'b0, 1'b0, 3, 1'b0, "/R8 pre");
    run_cfg(4, 2, 1, 1'b1, 1'b0, 5, 1'b0, "/R8 mid");
    run_cfg(2, 1, 0, 1'b0, 1'b0, 16, 1'b0, "/R8 restart");
    // R9: inputs scrambled between syncs have no effect
    run_cfg(3, 2, 2, 1'b0, 1'b0, 30, 1'b1, "/R9 hold");
    run_cfg(2, 4, 0, 1'b1, 1'b0, 30, 1'b1, "/R9 hold raw");
    run_cfg(5, 5, 0, 1'b0, 1'b1, 12, 1'b1, "/R9 hold byp");

    // constrained random
    for (int i = 0; i < 40; i++) begin
      int m, n, p;
      bit off, byp;
      m = int'($urandom_range(0, 15));
      n = int'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) m = (n < 15) ? n + 1 : n;
      else if ($urandom_range(0, 3) == 0) m = n;
      p = int'($urandom_range(0, 15));
      off = 1'($urandom_range(0, 1));
      byp = ($urandom_range(0, 7) == 0);
      run_cfg(m, n, p, off, byp, 2 * (m + n + 2) + p + 3, 1'($urandom_range(0, 1)), "/R7 rand");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule